// File: doc/BRIEF.md
# Multiplexed Display Dimming Sequencer

This block time-multiplexes a two- or three-grid vacuum fluorescent display. A prescaler divides the system clock into bit times, and a slot counter gives each grid a fixed slot of bit times in turn. During a slot the block drives one grid strobe low for as many bit times as the brightness code asks. It also presents that grid's segment word on the segment outputs, with a short tail that ends before the next slot begins.

A level input picks how many grids are scanned. The brightness code and the three per-grid segment words come from registers elsewhere. The block samples them only at slot boundaries, so a slot never changes part way through. The brightness is clamped so that each slot always ends with a dark gap. Within that gap the segments switch off a few bit times after the grid does and stay off until the next slot starts. A one-cycle pulse marks the first cycle of each grid-1 slot.

Top module: `vfd_mux_sequencer`

## Requirements
- R1: One bit time lasts TICKS_PER_BIT clock cycles, and one slot lasts SLOT_BITS bit times. A new slot starts on the clock edge that ends the last clock of the last bit time of the previous slot.
- R2: With dupSel high, slots cycle grid1, grid2, grid1 and so on, so a frame is 2 slots. With dupSel low, slots cycle grid1, grid2, grid3, so a frame is 3 slots. dupSel is examined at each slot boundary. From slot 3 with dupSel high, the next slot is grid1.
- R3: Grid outputs are active low, and gridN[i] drives grid i+1. At most one grid is low at any time. During the slot of grid i, gridN[i] is low exactly while the bit position within the slot is below the effective brightness.
- R4: The effective brightness equals dimCode (bit 0 is the LSB), clamped to at most SLOT_BITS-8. Every slot therefore keeps at least 8 bit times with all grids high.
- R5: During the slot of grid i, segOut equals that grid's sampled segment word, with bit k driving segment k+1. This holds while the bit position is below the effective brightness plus 3. At all other times segOut is all zero, and it is always zero when the effective brightness is 0.
- R6: When the brightness is at its maximum, segOut is zero for the last 5 bit times of every slot.
- R7: dimCode and the segment words are sampled only on the edge that starts a slot. Changes between boundaries do not reach the outputs until the next slot. The segment word sampled is the one belonging to the grid of the new slot.
- R8: While rstN is low, all grid outputs are high, segOut is zero and frameStart is low. After reset the sampled brightness and segment words are zero and the sequence starts in slot grid1 at bit position 0.
- R9: frameStart is high for exactly the first clock cycle of each grid1 slot that follows a slot boundary. Consecutive pulses are 2 or 3 slots apart, depending on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator-derived tick source) |
| rstN | input | 1 | Asynchronous active-low reset |
| dupSel | input | 1 | High: two-grid scan; low: three-grid scan |
| dimCode | input | DIM_W | Brightness code, in bit times of grid on-time per slot |
| segWordG1 | input | SEG_W | Segment word shown during the grid1 slot |
| segWordG2 | input | SEG_W | Segment word shown during the grid2 slot |
| segWordG3 | input | SEG_W | Segment word shown during the grid3 slot |
| gridN | output | 3 | Active-low grid strobes, bit 0 = grid1 |
| segOut | output | SEG_W | Segment outputs, high = lit |
| frameStart | output | 1 | One-cycle pulse at the start of each grid1 slot |

## Verification
The bench builds the block with TICKS_PER_BIT = 2 and SLOT_BITS = 64. This shrinks a triplex frame to 384 clocks, so dozens of complete frames fit in a short run. With a 6-bit code, the clamp threshold of 56 sits well below the largest code, 63. The segment width stays at 27, so a full segment word is exercised at every compare. Mode changes, brightness codes and segment words are changed mid-slot, so the run covers slot-boundary sampling and the duplex wrap taken from a triplex slot 3.

// File: rtl/vfd_seq_pkg.sv
package vfd_seq_pkg;
  localparam int NUM_GRIDS = 3;
  localparam int SLOT_W    = 2;

  typedef struct packed {
    logic slotLoad;   // edge that starts a new slot
    logic frameWrap;  // the new slot is grid1
  } seqStrobes_t;
endpackage

// File: rtl/vfd_seq_ctrl.sv
module vfd_seq_ctrl
  import vfd_seq_pkg::*;
#(
  parameter int TICKS_PER_BIT = 4,
  parameter int SLOT_BITS     = 1024,
  localparam int BIT_W  = $clog2(SLOT_BITS),
  localparam int TICK_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dupSel,
  output logic [BIT_W-1:0]  bitPos,
  output logic [SLOT_W-1:0] curSlot,
  output logic [SLOT_W-1:0] nextSlot,
  output seqStrobes_t       strb,
  output logic              frameStart
);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);

  logic [TICK_W-1:0] tickCnt;
  logic              bitTick;
  logic [SLOT_W-1:0] slotInc;
  logic [SLOT_W-1:0] slotsInFrame;

  assign bitTick      = (tickCnt == TICK_LAST);
  assign slotsInFrame = dupSel ? SLOT_W'(2) : SLOT_W'(3);
  assign slotInc      = curSlot + SLOT_W'(1);
  assign nextSlot     = (slotInc >= slotsInFrame) ? '0 : slotInc;

  always_comb begin
    strb.slotLoad  = bitTick && (bitPos == BIT_LAST);
    strb.frameWrap = strb.slotLoad && (nextSlot == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt    <= '0;
      bitPos     <= '0;
      curSlot    <= '0;
      frameStart <= 1'b0;
    end else begin
      tickCnt    <= bitTick ? '0 : tickCnt + TICK_W'(1);
      frameStart <= strb.frameWrap;
      if (bitTick) begin
        if (strb.slotLoad) begin
          bitPos  <= '0;
          curSlot <= nextSlot;
        end else begin
          bitPos <= bitPos + BIT_W'(1);
        end
      end
    end
  end

  // R1
  bit_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.slotLoad |=> (bitPos == '0));
  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    curSlot < SLOT_W'(NUM_GRIDS));
  // R9
  frame_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (curSlot == '0 && bitPos == '0));
endmodule

// File: rtl/vfd_seq_datapath.sv
module vfd_seq_datapath
  import vfd_seq_pkg::*;
#(
  parameter int SLOT_BITS = 1024,
  parameter int SEG_W     = 27,
  parameter int GRID_GAP  = 8,
  parameter int SEG_BLANK = 5,
  localparam int DIM_W    = $clog2(SLOT_BITS),
  localparam int SEG_TAIL = GRID_GAP - SEG_BLANK
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [DIM_W-1:0]  bitPos,
  input  logic [SLOT_W-1:0] curSlot,
  input  logic [SLOT_W-1:0] nextSlot,
  input  logic [DIM_W-1:0]  dimCode,
  input  logic [SEG_W-1:0]  segWordG1,
  input  logic [SEG_W-1:0]  segWordG2,
  input  logic [SEG_W-1:0]  segWordG3,
  output logic [NUM_GRIDS-1:0] gridN,
  output logic [SEG_W-1:0]  segOut
);
  localparam logic [DIM_W-1:0] DUTY_MAX = DIM_W'(SLOT_BITS - GRID_GAP);

  logic [DIM_W-1:0] dimShadow;
  logic [SEG_W-1:0] segShadow;
  logic [DIM_W-1:0] dimClamped;
  logic [SEG_W-1:0] segPick;
  logic             gridOn;
  logic             segOn;

  assign dimClamped = (dimCode > DUTY_MAX) ? DUTY_MAX : dimCode;

  always_comb begin
    case (nextSlot)
      2'd1:    segPick = segWordG2;
      2'd2:    segPick = segWordG3;
      default: segPick = segWordG1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dimShadow <= '0;
      segShadow <= '0;
    end else if (strb.slotLoad) begin
      dimShadow <= dimClamped;
      segShadow <= segPick;
    end
  end

  assign gridOn = (bitPos < dimShadow);
  assign segOn  = (dimShadow != '0) &&
                  ({1'b0, bitPos} < ({1'b0, dimShadow} + (DIM_W+1)'(SEG_TAIL)));
  assign segOut = segOn ? segShadow : '0;

  for (genvar g = 0; g < NUM_GRIDS; g++) begin : gen_grid
    assign gridN[g] = !(gridOn && (curSlot == SLOT_W'(g)));
  end

  // R3
  one_grid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~gridN));
  // R4
  dim_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    dimShadow <= DUTY_MAX);
  // R7
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.slotLoad |=> $stable(segShadow) && $stable(dimShadow));
  // R5
  seg_with_grid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gridN != '1) |-> (segOut == segShadow));
endmodule

// File: rtl/vfd_mux_sequencer.sv
module vfd_mux_sequencer
  import vfd_seq_pkg::*;
#(
  parameter int TICKS_PER_BIT = 4,
  parameter int SLOT_BITS     = 1024,
  parameter int SEG_W         = 27,
  parameter int GRID_GAP      = 8,
  parameter int SEG_BLANK     = 5,
  localparam int DIM_W        = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dupSel,
  input  logic [DIM_W-1:0] dimCode,
  input  logic [SEG_W-1:0] segWordG1,
  input  logic [SEG_W-1:0] segWordG2,
  input  logic [SEG_W-1:0] segWordG3,
  output logic [2:0]       gridN,
  output logic [SEG_W-1:0] segOut,
  output logic             frameStart
);
  seqStrobes_t       strb;
  logic [DIM_W-1:0]  bitPos;
  logic [SLOT_W-1:0] curSlot;
  logic [SLOT_W-1:0] nextSlot;

  vfd_seq_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .SLOT_BITS(SLOT_BITS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .dupSel(dupSel),
    .bitPos(bitPos), .curSlot(curSlot), .nextSlot(nextSlot),
    .strb(strb), .frameStart(frameStart)
  );

  vfd_seq_datapath #(
    .SLOT_BITS(SLOT_BITS), .SEG_W(SEG_W),
    .GRID_GAP(GRID_GAP), .SEG_BLANK(SEG_BLANK)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .bitPos(bitPos), .curSlot(curSlot), .nextSlot(nextSlot),
    .dimCode(dimCode),
    .segWordG1(segWordG1), .segWordG2(segWordG2), .segWordG3(segWordG3),
    .gridN(gridN), .segOut(segOut)
  );
endmodule

// File: tb/vfd_mux_sequencer_tb.sv
module vfd_mux_sequencer_tb_top;
  localparam int T     = 2;
  localparam int S     = 64;
  localparam int SEG_W = 27;
  localparam int DIM_W = $clog2(S);
  localparam int DMAX  = S - 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dupSel = 1'b0;
  logic [DIM_W-1:0] dimCode = '0;
  logic [SEG_W-1:0] segWordG1 = '0, segWordG2 = '0, segWordG3 = '0;
  logic [2:0] gridN;
  logic [SEG_W-1:0] segOut;
  logic frameStart;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vfd_mux_sequencer #(.TICKS_PER_BIT(T), .SLOT_BITS(S), .SEG_W(SEG_W)) dut_i (
    .clk(clk), .rstN(rstN), .dupSel(dupSel), .dimCode(dimCode),
    .segWordG1(segWordG1), .segWordG2(segWordG2), .segWordG3(segWordG3),
    .gridN(gridN), .segOut(segOut), .frameStart(frameStart)
  );

  // Reference state derived from the requirements
  int mTick, mBit, mSlot, mDim;
  logic [SEG_W-1:0] mSeg;
  bit mFrame;

  function automatic int clampDim(int d);
    return (d > DMAX) ? DMAX : d;
  endfunction

  function automatic logic [2:0] expGrid(int slot, int b, int d);
    logic [2:0] g = 3'b111;
    if (b < d) g[slot] = 1'b0;
    return g;
  endfunction

  function automatic logic [SEG_W-1:0] expSeg(int b, int d, logic [SEG_W-1:0] w);
    return (d != 0 && b < d + 3) ? w : '0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTick <= 0; mBit <= 0; mSlot <= 0; mDim <= 0; mSeg <= '0; mFrame <= 0;
    end else begin
      mFrame <= 0;
      if (mTick == T - 1) begin
        mTick <= 0;
        if (mBit == S - 1) begin
          int ns;
          ns = (mSlot + 1 >= (dupSel ? 2 : 3)) ? 0 : mSlot + 1;
          mBit <= 0; mSlot <= ns;
          mDim <= clampDim(int'(dimCode));
          mSeg <= (ns == 0) ? segWordG1 : (ns == 1) ? segWordG2 : segWordG3;
          mFrame <= (ns == 0);
        end else mBit <= mBit + 1;
      end else mTick <= mTick + 1;
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      check(gridN == expGrid(mSlot, mBit, mDim), "R3 grid strobes", 64'(gridN),
            64'(expGrid(mSlot, mBit, mDim)));
      check(segOut == expSeg(mBit, mDim, mSeg), "R5 segment gating", 64'(segOut),
            64'(expSeg(mBit, mDim, mSeg)));
      check(frameStart == mFrame, "R9 frame pulse", 64'(frameStart), 64'(mFrame));
      if (rstN && mDim == DMAX && mBit >= S - 5)
        check(segOut == '0, "R6 dark tail", 64'(segOut), 64'd0);
    end
  end

  // Frame period measurement
  int lastFrame = -1, cyc = 0;
  bit modeMoved = 0;
  logic lastDup = 0;
  always @(negedge clk) begin
    cyc++;
    if (dupSel != lastDup) modeMoved = 1;
    lastDup = dupSel;
    if (!done && rstN && frameStart) begin
      if (lastFrame >= 0 && !modeMoved)
        check(cyc - lastFrame == (dupSel ? 2 : 3) * S * T, "R1 R2 frame period",
              64'(cyc - lastFrame), 64'((dupSel ? 2 : 3) * S * T));
      lastFrame = cyc;
      modeMoved = 0;
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  // Count grid-low cycles in one slot of grid1 at clamped maximum (R4)
  task automatic measureOnTime(int expCycles);
    int cnt = 0;
    @(posedge frameStart);
    @(negedge clk);
    for (int i = 0; i < S * T; i++) begin
      if (gridN[0] == 1'b0) cnt++;
      @(negedge clk);
    end
    check(cnt == expCycles, "R4 on-time", 64'(cnt), 64'(expCycles));
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  initial begin
    void'($urandom(32'd1234));
    #2;
    @(negedge clk);
    // R8 reset state
    check(gridN == 3'b111, "R8 reset grids", 64'(gridN), 64'h7);
    check(segOut == '0, "R8 reset segments", 64'(segOut), 64'd0);
    check(frameStart == 1'b0, "R8 reset pulse", 64'(frameStart), 64'd0);
    waitCycles(3);
    rstN = 1'b1;

    // Directed: triplex, code above clamp, distinct words (R4, R6)
    dupSel = 1'b0; dimCode = 6'd63;
    segWordG1 = 27'h5A5A5A5; segWordG2 = 27'h1234567; segWordG3 = 27'h7FFFFFF;
    measureOnTime(DMAX * T);
    waitCycles(S * T * 3);

    // Directed: dim 0 keeps everything dark, dim 1 shortest window (R5)
    dimCode = 6'd0; waitCycles(S * T * 4);
    dimCode = 6'd1; waitCycles(S * T * 4);
    measureOnTime(1 * T);

    // Directed: duplex, then switch to duplex while in slot grid3 (R2)
    dupSel = 1'b1; dimCode = 6'd40; waitCycles(S * T * 5);
    dupSel = 1'b0; waitCycles(S * T * 2 + S); // inside grid3 slot
    dupSel = 1'b1; waitCycles(S * T * 4);

    // Random: inputs change at arbitrary points mid-slot (R7)
    for (int k = 0; k < 120; k++) begin
      dimCode   = DIM_W'($urandom);
      segWordG1 = SEG_W'($urandom);
      segWordG2 = SEG_W'($urandom);
      segWordG3 = SEG_W'($urandom);
      if ($urandom % 8 == 0) dupSel = ~dupSel;
      waitCycles(1 + $urandom % (S * T));
    end

    // Directed: max brightness duplex, tail gap (R6)
    dupSel = 1'b1; dimCode = DIM_W'(DMAX);
    waitCycles(S * T * 6);
    finishRun();
  end

  initial begin
    #(200000 * 10 - 100);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end
endmodule